// File: doc/BRIEF.md
# Receiver Host Register Interface

This block is the host side of a serial word receiver. It connects the receive path to a controlling processor over an 8-bit parallel bus. A select line picks between the register pair and the data port. With select high, a write loads a write-only control register and a read returns a status byte. With select low, a read fetches the next byte of the held word. Each received 32-bit word is handed over as four bytes, least significant byte first.

The receive path offers one completed word at a time. It does so with a one-cycle valid strobe and two error indications, bad parity and bad framing. The block decides whether to accept the word and stores it. It drives a ready line and a first-byte line, and it keeps sticky error flags until the host reads the status. A self-clearing control bit keeps ready low for exactly one word. The first-byte line follows the chosen transfer mode: byte mode or full-word mode.

Top module: `rxh_host_if`

## Requirements
- R1: With host_sel=1, a write loads the control byte. Bit 0 is receiver enable, bit 1 is parity check enable, bit 2 selects word mode (1 = full-word, 0 = byte), bit 3 is the ready hold, and bits 7:4 are ignored. A write with host_sel=0 changes nothing.
- R2: Reset is synchronous and active high. It loads control 0x03 (receiver on, parity check on, byte mode, no hold) and clears ready, first-byte, all flags and host_rdata.
- R3: While receiver enable is 0, incoming words are ignored. Ready stays low and no flag is set.
- R4: An accepted word without a framing error raises ready one cycle after its strobe. Ready stays high until the fourth data read. Each data read returns the next byte on host_rdata one cycle later, starting with bits 7:0. A data read with no word held returns 0x00.
- R5: An accepted word with a framing error is discarded and sets the framing flag (status bit 3).
- R6: With parity check enabled, a word marked bad parity sets the parity flag (status bit 1) and is still delivered. With parity check disabled, the flag stays clear.
- R7: If the hold bit is set when a word is accepted, ready stays low for that word. The word is still readable, and the hold bit returns to 0.
- R8: First-byte (output and status bit 4) rises with each stored word. In byte mode it falls on the first data read. In word mode it falls on the fourth. The hold bit does not affect it.
- R9: A good word that arrives while ready is high sets the overrun flag (status bit 2). It replaces the held word, and reading restarts at its low byte.
- R10: A status read returns {3'b000, first, framing, overrun, parity, ready} as they stood before the read. It then clears the three error flags, but a flag set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | 1 = registers, 0 = data port |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| rx_word_vld | input | 1 | Receive path offers a word this cycle |
| rx_word | input | 32 | Offered word |
| rx_par_bad | input | 1 | Offered word failed parity |
| rx_frame_bad | input | 1 | Offered word failed framing |
| rdy_o | output | 1 | Word ready for the host |
| first_o | output | 1 | First-byte / valid-word indication |

## Verification
Every result is registered once, so host_rdata, rdy_o and first_o all reflect a strobe presented before a rising edge just after that edge. The bench drives inputs and samples outputs on the falling edge. Its reference model advances on the same rising edge, so each comparison lands exactly one cycle after the stimulus. Directed checks are made on the falling edge that follows the strobe. Status contents are checked against hand-derived bytes, including the cases where a flag is set and cleared in the same cycle.

// File: rtl/rxh_pkg.sv
package rxh_pkg;

    parameter int BUS_W     = 8;
    parameter int NUM_BYTES = 4;

    localparam int WORD_W    = BUS_W * NUM_BYTES;
    localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
    localparam int CTRL_USED = 4;
    localparam int STAT_USED = 5;
    localparam int NUM_FLAGS = 3;

    // control byte, bit 0 first
    typedef struct packed {
        logic [BUS_W-CTRL_USED-1:0] spare;
        logic                       hold_one;
        logic                       word_mode;
        logic                       par_chk;
        logic                       rx_on;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{spare: '0, hold_one: 1'b0, word_mode: 1'b0,
                                   par_chk: 1'b1, rx_on: 1'b1};

    // status byte, bit 0 first
    typedef struct packed {
        logic [BUS_W-STAT_USED-1:0] spare;
        logic                       first;
        logic                       frame_err;
        logic                       overrun;
        logic                       par_err;
        logic                       ready;
    } stat_t;

    // sticky flag set requests, parity at bit 0
    typedef struct packed {
        logic frm;
        logic ovr;
        logic par;
    } flag_set_t;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_CTRL_WR,
        ACC_STAT_RD,
        ACC_DATA_RD
    } acc_e;

    // a register read takes precedence over a simultaneous write
    function automatic acc_e decode_access(input logic sel, input logic wr, input logic rd);
        if (sel && rd)       return ACC_STAT_RD;
        else if (sel && wr)  return ACC_CTRL_WR;
        else if (!sel && rd) return ACC_DATA_RD;
        else                 return ACC_IDLE;
    endfunction

    function automatic logic [BUS_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                   input logic [IDX_W-1:0]  i);
        return w[int'(i)*BUS_W +: BUS_W];
    endfunction

endpackage

// File: rtl/rxh_ctrl_reg.sv
module rxh_ctrl_reg
    import rxh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  acc_e             acc,
    input  logic [BUS_W-1:0] wdata,
    input  logic             rx_word_vld,
    output ctrl_t            ctrl_q
);

    logic accept;

    assign accept = rx_word_vld && ctrl_q.rx_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else if (acc == ACC_CTRL_WR) begin
            ctrl_q <= ctrl_t'(wdata);
        end else if (accept && ctrl_q.hold_one) begin
            // the hold covers exactly one accepted word
            ctrl_q.hold_one <= 1'b0;
        end
    end

endmodule

// File: rtl/rxh_word_buf.sv
module rxh_word_buf
    import rxh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic              rx_on,
    input  logic              hold_one,
    input  logic              word_mode,
    input  logic              rx_word_vld,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_frame_bad,
    output logic              ready_o,
    output logic              first_o,
    output logic [BUS_W-1:0]  rd_byte_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pend_q;
    logic              blk_q;
    logic              first_q;
    logic              good;
    logic              take_byte;

    assign good      = rx_word_vld && rx_on && !rx_frame_bad;
    assign take_byte = (acc == ACC_DATA_RD) && pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
            blk_q   <= 1'b0;
            first_q <= 1'b0;
        end else if (good) begin
            word_q  <= rx_word;
            idx_q   <= '0;
            pend_q  <= 1'b1;
            blk_q   <= hold_one;
            first_q <= 1'b1;
        end else if (take_byte) begin
            if (idx_q == LAST_IDX) begin
                idx_q   <= '0;
                pend_q  <= 1'b0;
                blk_q   <= 1'b0;
                first_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
                if (!word_mode) begin
                    first_q <= 1'b0;
                end
            end
        end
    end

    assign ready_o   = pend_q && !blk_q;
    assign first_o   = first_q;
    assign rd_byte_o = pend_q ? pick_byte(word_q, idx_q) : '0;

endmodule

// File: rtl/rxh_flags.sv
module rxh_flags
    import rxh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  acc_e                 acc,
    input  logic                 rx_on,
    input  logic                 par_chk,
    input  logic                 ready_now,
    input  logic                 rx_word_vld,
    input  logic                 rx_par_bad,
    input  logic                 rx_frame_bad,
    output logic [NUM_FLAGS-1:0] flag_q
);

    flag_set_t             set_s;
    logic [NUM_FLAGS-1:0]  set_v;
    logic                  accept;
    logic                  good;
    logic                  clr;

    assign accept = rx_word_vld && rx_on;
    assign good   = accept && !rx_frame_bad;
    assign clr    = (acc == ACC_STAT_RD);

    always_comb begin
        set_s.par = good && par_chk && rx_par_bad;
        set_s.ovr = good && ready_now;
        set_s.frm = accept && rx_frame_bad;
    end

    assign set_v = set_s;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[g] <= 1'b0;
            end else if (set_v[g]) begin
                flag_q[g] <= 1'b1;
            end else if (clr) begin
                flag_q[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rxh_host_if.sv
module rxh_host_if
    import rxh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BUS_W-1:0]  host_wdata,
    output logic [BUS_W-1:0]  host_rdata,
    input  logic              rx_word_vld,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_par_bad,
    input  logic              rx_frame_bad,
    output logic              rdy_o,
    output logic              first_o
);

    acc_e                 acc;
    ctrl_t                ctrl_q;
    logic [NUM_FLAGS-1:0] flag_q;
    logic                 ready_w;
    logic                 first_w;
    logic [BUS_W-1:0]     rd_byte;
    stat_t                stat;
    logic [BUS_W-1:0]     rdata_q;

    assign acc = decode_access(host_sel, host_wr, host_rd);

    rxh_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .wdata       (host_wdata),
        .rx_word_vld (rx_word_vld),
        .ctrl_q      (ctrl_q)
    );

    rxh_word_buf u_buf (
        .clk          (clk),
        .rst          (rst),
        .acc          (acc),
        .rx_on        (ctrl_q.rx_on),
        .hold_one     (ctrl_q.hold_one),
        .word_mode    (ctrl_q.word_mode),
        .rx_word_vld  (rx_word_vld),
        .rx_word      (rx_word),
        .rx_frame_bad (rx_frame_bad),
        .ready_o      (ready_w),
        .first_o      (first_w),
        .rd_byte_o    (rd_byte)
    );

    rxh_flags u_flags (
        .clk          (clk),
        .rst          (rst),
        .acc          (acc),
        .rx_on        (ctrl_q.rx_on),
        .par_chk      (ctrl_q.par_chk),
        .ready_now    (ready_w),
        .rx_word_vld  (rx_word_vld),
        .rx_par_bad   (rx_par_bad),
        .rx_frame_bad (rx_frame_bad),
        .flag_q       (flag_q)
    );

    always_comb begin
        stat           = '0;
        stat.ready     = ready_w;
        stat.par_err   = flag_q[0];
        stat.overrun   = flag_q[1];
        stat.frame_err = flag_q[2];
        stat.first     = first_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            case (acc)
                ACC_STAT_RD: rdata_q <= stat;
                ACC_DATA_RD: rdata_q <= rd_byte;
                default:     rdata_q <= rdata_q;
            endcase
        end
    end

    assign host_rdata = rdata_q;
    assign rdy_o      = ready_w;
    assign first_o    = first_w;

endmodule

// File: rtl/rxh_host_if_chk.sv
module rxh_host_if_chk
    import rxh_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 host_sel,
    input logic                 host_wr,
    input logic                 host_rd,
    input logic [BUS_W-1:0]     host_wdata,
    input logic [BUS_W-1:0]     host_rdata,
    input logic                 rx_word_vld,
    input logic                 rx_frame_bad,
    input logic                 rdy_o,
    input logic                 first_o,
    input ctrl_t                ctrl_q,
    input logic [NUM_FLAGS-1:0] flag_q
);

    logic accept;
    logic stat_rd;
    logic ctrl_wr;

    assign accept  = rx_word_vld && ctrl_q.rx_on;
    assign stat_rd = host_sel && host_rd;
    assign ctrl_wr = host_sel && host_wr && !host_rd;

    p_ctrl_write_r1: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl_q == ctrl_t'($past(host_wdata))));

    p_reset_clears_r2: assert property (@(posedge clk)
        rst |=> (host_rdata == '0 && !rdy_o && !first_o && ctrl_q == CTRL_RST && flag_q == '0));

    p_disabled_ignores_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_word_vld && !ctrl_q.rx_on && !rdy_o) |=> !rdy_o);

    p_good_word_ready_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && !rx_frame_bad && !ctrl_q.hold_one) |=> rdy_o);

    p_frame_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && rx_frame_bad) |=> flag_q[2]);

    p_frame_no_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && rx_frame_bad && !rdy_o) |=> !rdy_o);

    p_hold_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && !rx_frame_bad && ctrl_q.hold_one) |=> !rdy_o);

    p_hold_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && ctrl_q.hold_one && !ctrl_wr) |=> !ctrl_q.hold_one);

    p_word_mode_first_r8: assert property (@(posedge clk) disable iff (rst)
        (rdy_o && ctrl_q.word_mode) |-> first_o);

    p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && !rx_frame_bad && rdy_o) |=> flag_q[1]);

    p_stat_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !rx_word_vld) |=> (flag_q == '0));

endmodule

bind rxh_host_if rxh_host_if_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_sel     (host_sel),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .rx_word_vld  (rx_word_vld),
    .rx_frame_bad (rx_frame_bad),
    .rdy_o        (rdy_o),
    .first_o      (first_o),
    .ctrl_q       (ctrl_q),
    .flag_q       (flag_q)
);

// File: tb/rxh_host_if_tb_top.sv
`timescale 1ns/1ps
module rxh_host_if_tb_top;

    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        rx_word_vld = 1'b0;
    logic [31:0] rx_word = 32'h0;
    logic        rx_par_bad = 1'b0;
    logic        rx_frame_bad = 1'b0;
    logic        rdy_o;
    logic        first_o;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R2";

    always #10 clk = ~clk;

    rxh_host_if dut_i (
        .clk          (clk),
        .rst          (rst),
        .host_sel     (host_sel),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .rx_word_vld  (rx_word_vld),
        .rx_word      (rx_word),
        .rx_par_bad   (rx_par_bad),
        .rx_frame_bad (rx_frame_bad),
        .rdy_o        (rdy_o),
        .first_o      (first_o)
    );

    // behavioural reference: bytes still to be read sit in a queue
    logic [7:0] m_q[$];
    bit         m_blk, m_rx_on, m_par_chk, m_wmode, m_hold;
    bit         m_par, m_ovr, m_frm;
    logic [7:0] m_rdata;

    function automatic bit m_ready();
        return (m_q.size() > 0) && !m_blk;
    endfunction

    function automatic bit m_first();
        return m_wmode ? (m_q.size() > 0) : (m_q.size() == 4);
    endfunction

    always @(posedge clk) begin
        bit a_stat, a_ctrl, a_data, accept, good, rdy_old, first_old;
        if (rst) begin
            m_q.delete();
            m_blk = 0; m_rx_on = 1; m_par_chk = 1; m_wmode = 0; m_hold = 0;
            m_par = 0; m_ovr = 0; m_frm = 0;
            m_rdata = 8'h00;
        end else begin
            a_stat    = host_sel && host_rd;
            a_ctrl    = host_sel && host_wr && !host_rd;
            a_data    = !host_sel && host_rd;
            accept    = rx_word_vld && m_rx_on;
            good      = accept && !rx_frame_bad;
            rdy_old   = m_ready();
            first_old = m_first();
            if (a_stat)
                m_rdata = {3'b000, first_old, m_frm, m_ovr, m_par, rdy_old};
            else if (a_data)
                m_rdata = (m_q.size() > 0) ? m_q[0] : 8'h00;
            if (good) begin
                m_q.delete();
                for (int k = 0; k < 4; k++) m_q.push_back(rx_word[8*k +: 8]);
                m_blk = m_hold;
            end else if (a_data && m_q.size() > 0) begin
                void'(m_q.pop_front());
                if (m_q.size() == 0) m_blk = 0;
            end
            if (a_stat) begin
                m_par = 0; m_ovr = 0; m_frm = 0;
            end
            if (good && m_par_chk && rx_par_bad) m_par = 1;
            if (good && rdy_old) m_ovr = 1;
            if (accept && rx_frame_bad) m_frm = 1;
            if (a_ctrl) begin
                m_rx_on   = host_wdata[0];
                m_par_chk = host_wdata[1];
                m_wmode   = host_wdata[2];
                m_hold    = host_wdata[3];
            end else if (accept && m_hold) begin
                m_hold = 0;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, "model rdy_o", {31'd0, rdy_o}, {31'd0, m_ready()});
            check(cur_req, "model first_o", {31'd0, first_o}, {31'd0, m_first()});
            check(cur_req, "model host_rdata", {24'd0, host_rdata}, {24'd0, m_rdata});
        end
    end

    task automatic drive(input bit sel, input bit wr, input bit rd, input logic [7:0] wd,
                         input bit vld, input logic [31:0] w, input bit pb, input bit fb);
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = wd;
        rx_word_vld = vld; rx_word = w; rx_par_bad = pb; rx_frame_bad = fb;
    endtask

    task automatic idle();
        drive(0, 0, 0, 8'h00, 0, 32'h0, 0, 0);
    endtask

    task automatic ctrl_wr(input logic [7:0] v);
        drive(1, 1, 0, v, 0, 32'h0, 0, 0);
        idle();
    endtask

    task automatic send(input logic [31:0] w, input bit pb, input bit fb);
        drive(0, 0, 0, 8'h00, 1, w, pb, fb);
        idle();
    endtask

    task automatic stat_expect(input string req, input logic [7:0] exp);
        drive(1, 0, 1, 8'h00, 0, 32'h0, 0, 0);
        idle();
        check(req, "status byte", {24'd0, host_rdata}, {24'd0, exp});
    endtask

    task automatic data_expect(input string req, input logic [7:0] exp);
        drive(0, 0, 1, 8'h00, 0, 32'h0, 0, 0);
        idle();
        check(req, "data byte", {24'd0, host_rdata}, {24'd0, exp});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        // R2 reset state
        cur_req = "R2";
        check("R2", "rdy after reset", {31'd0, rdy_o}, 32'd0);
        check("R2", "first after reset", {31'd0, first_o}, 32'd0);
        check("R2", "rdata after reset", {24'd0, host_rdata}, 32'd0);
        stat_expect("R2", 8'h00);

        // R4 byte order and ready span, R8 byte-mode first
        cur_req = "R4";
        send(32'hA1B2_C3D4, 0, 0);
        check("R4", "rdy after word", {31'd0, rdy_o}, 32'd1);
        check("R8", "first after word", {31'd0, first_o}, 32'd1);
        data_expect("R4", 8'hD4);
        check("R8", "first after byte 0 (byte mode)", {31'd0, first_o}, 32'd0);
        check("R4", "rdy mid word", {31'd0, rdy_o}, 32'd1);
        data_expect("R4", 8'hC3);
        data_expect("R4", 8'hB2);
        data_expect("R4", 8'hA1);
        check("R4", "rdy after 4th read", {31'd0, rdy_o}, 32'd0);
        data_expect("R4", 8'h00);

        // R6 parity, R10 clear on read
        cur_req = "R6";
        send(32'h1122_3344, 1, 0);
        stat_expect("R6", 8'h13);
        stat_expect("R10", 8'h11);
        data_expect("R6", 8'h44);
        data_expect("R6", 8'h33);
        data_expect("R6", 8'h22);
        data_expect("R6", 8'h11);
        ctrl_wr(8'h01);
        send(32'h5566_7788, 1, 0);
        stat_expect("R6", 8'h11);
        data_expect("R6", 8'h88);
        data_expect("R6", 8'h77);
        data_expect("R6", 8'h66);
        data_expect("R6", 8'h55);
        ctrl_wr(8'h03);

        // R5 framing error
        cur_req = "R5";
        send(32'hDEAD_BEEF, 0, 1);
        check("R5", "rdy after framing error", {31'd0, rdy_o}, 32'd0);
        stat_expect("R5", 8'h08);
        stat_expect("R10", 8'h00);
        data_expect("R5", 8'h00);

        // R9 overwrite
        cur_req = "R9";
        send(32'h0102_0304, 0, 0);
        send(32'h0A0B_0C0D, 0, 0);
        stat_expect("R9", 8'h15);
        data_expect("R9", 8'h0D);
        data_expect("R9", 8'h0C);
        data_expect("R9", 8'h0B);
        data_expect("R9", 8'h0A);
        send(32'h0102_0304, 0, 0);
        data_expect("R9", 8'h04);
        send(32'h5060_7080, 0, 0);
        data_expect("R9", 8'h80);
        stat_expect("R9", 8'h05);
        data_expect("R9", 8'h70);
        data_expect("R9", 8'h60);
        data_expect("R9", 8'h50);

        // R7 one-word hold
        cur_req = "R7";
        ctrl_wr(8'h0B);
        send(32'hCAFE_F00D, 0, 0);
        check("R7", "rdy held", {31'd0, rdy_o}, 32'd0);
        check("R8", "first despite hold", {31'd0, first_o}, 32'd1);
        stat_expect("R7", 8'h10);
        data_expect("R7", 8'h0D);
        data_expect("R7", 8'hF0);
        data_expect("R7", 8'hFE);
        data_expect("R7", 8'hCA);
        send(32'h1234_5678, 0, 0);
        check("R7", "rdy after self clear", {31'd0, rdy_o}, 32'd1);
        data_expect("R7", 8'h78);
        data_expect("R7", 8'h56);
        data_expect("R7", 8'h34);
        data_expect("R7", 8'h12);

        // R8 word mode
        cur_req = "R8";
        ctrl_wr(8'h07);
        send(32'h9ABC_DEF0, 0, 0);
        data_expect("R8", 8'hF0);
        check("R8", "first after byte 0 (word mode)", {31'd0, first_o}, 32'd1);
        data_expect("R8", 8'hDE);
        data_expect("R8", 8'hBC);
        check("R8", "first before last byte", {31'd0, first_o}, 32'd1);
        data_expect("R8", 8'h9A);
        check("R8", "first after last byte", {31'd0, first_o}, 32'd0);
        ctrl_wr(8'h03);

        // R3 receiver disabled
        cur_req = "R3";
        ctrl_wr(8'h02);
        send(32'h3333_3333, 1, 1);
        check("R3", "rdy while disabled", {31'd0, rdy_o}, 32'd0);
        stat_expect("R3", 8'h00);
        ctrl_wr(8'h03);

        // R1 data-port write ignored
        cur_req = "R1";
        drive(0, 1, 0, 8'h00, 0, 32'h0, 0, 0);
        idle();
        send(32'h4444_4444, 0, 0);
        check("R1", "rdy after data-port write", {31'd0, rdy_o}, 32'd1);
        stat_expect("R1", 8'h11);
        data_expect("R1", 8'h44);
        data_expect("R1", 8'h44);
        data_expect("R1", 8'h44);
        data_expect("R1", 8'h44);

        // R10 set wins over clear
        cur_req = "R10";
        drive(1, 0, 1, 8'h00, 1, 32'h7777_7777, 0, 1);
        idle();
        check("R10", "status during set", {24'd0, host_rdata}, 32'h00);
        stat_expect("R10", 8'h08);
        stat_expect("R10", 8'h00);

        repeat (2) idle();
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule